// File: doc/BRIEF.md
# Event Timer Register Block with Main Counter

This block is the register front end of a multi-channel event timer. It sits behind a 1 KiB window that is reached only with aligned 32-bit words over a plain valid/write/address/data port. The window holds a read-only capability pair, a general configuration word, an interrupt status word, and a free-running 64-bit main counter. It also holds one register window per timer channel. The per-channel configuration, comparator and message-route values go out on flat output buses, and the comparator channels downstream read them there.

Setting the global run bit starts the main counter from whatever value is stored in it. While the bit is set, the counter advances once per clock. Clearing the bit freezes the counter and disarms every channel. Software may load either 32-bit half of the counter at any time. A load takes effect at the clock edge of the request, and that edge does not also add one. The downstream comparators raise status bits through a set input. Software clears those bits by writing ones.

Top module: `evtTimerRegs`

## Requirements
- R1: After reset the counter, the general configuration and the status word are zero. Every channel's configuration low word reads 0x00000030: bit 4 is the periodic capability and bit 5 is the 64-bit capability. The high word reads 0x00000004, which is the allowed-route bitmap with bit 2 set. The comparator reads all ones and the route reads zero.
- R2: Offset 0x000 reads 0x8086A001 with (NUM_CH-1) ORed into bits 12:8. Offset 0x004 reads PERIOD_FS. Writes to both offsets are ignored.
- R3: General configuration sits at 0x010. Bit 0 is the run enable and bit 1 is the legacy-route select, which drives `legacyRoute`. Only these two bits take written data, and the other bits read zero. Offset 0x014 reads zero and ignores writes.
- R4: The counter reads at 0x0F0 (low half) and 0x0F4 (high half). It grows by exactly one per clock edge while the run bit is set. While the run bit is clear it holds its value and reads return that frozen value.
- R5: A write to one counter half loads that half at the edge of the request, including while the counter runs, and leaves the other half intact. There is no increment on that edge.
- R6: Channel n's window starts at 0x100 + 0x20*n. In the configuration low word at +0x0, only the bits of mask 0x00007F4E take written data; the capability bits stay set and all other bits stay zero. The high word at +0x4 is read-only.
- R7: The comparator halves at +0x8 and +0xC, and the route halves at +0x10 and +0x14, each store the written word independently.
- R8: `chArm[n]` is high exactly when the run bit is set and bit 2 of channel n's configuration is set. Clearing the run bit drops every arm.
- R9: The status word is at 0x020. Bit n is set by `stsSet[n]` only while the run bit is set. Writing a 1 to bit n clears it, and writing a 0 has no effect.
- R10: A channel index at or beyond NUM_CH, channel slots +0x18 and +0x1C, and every unmapped offset below 0x100 all read zero, and writes to them change nothing.
- R11: Read data appears on `busRdata` at the clock edge of the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 10 | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| stsSet | input | NUM_CH | Per-channel status set requests |
| busRdata | output | 32 | Registered read data |
| counterOut | output | 64 | Main counter value |
| counterRun | output | 1 | Global run bit |
| legacyRoute | output | 1 | Legacy-route select bit |
| chArm | output | NUM_CH | Per-channel armed indication |
| chCfgOut | output | NUM_CH*32 | Channel configuration low words |
| chCmpOut | output | NUM_CH*64 | Channel comparator values |
| chRouteOut | output | NUM_CH*64 | Channel message-route values |

## Verification
Every result in this block is due one edge after its stimulus. A write updates the stored register and the flat outputs at the request edge. A read presents its data at its own edge. A counter value read at edge t is the count before t's increment. The bench drives on falling edges, holds each request across exactly one rising edge, and samples on the next falling edge. Running-counter checks use the exact difference between two reads a known number of edges apart, so a wrong increment rule shows up as a numeric mismatch.

// File: rtl/evtTimerPkg.sv
package evtTimerPkg;
  localparam int ADDR_W   = 10;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 64;
  localparam int CH_IDX_W = 5;
  localparam logic [31:0] CAP_BASE    = 32'h8086_A001;
  localparam logic [31:0] CH_CFG_MASK = 32'h0000_7F4E;
  localparam logic [31:0] CH_CAP_BITS = 32'h0000_0030;
  localparam logic [31:0] CH_CFG_HI   = 32'h0000_0004;
  localparam logic [1:0]  GEN_MASK    = 2'b11;

  typedef enum logic [3:0] {
    RD_ZERO, RD_CAPLO, RD_CAPHI, RD_GEN, RD_STS, RD_CNTLO, RD_CNTHI,
    RD_CHCFGLO, RD_CHCFGHI, RD_CMPLO, RD_CMPHI, RD_RTLO, RD_RTHI
  } rdSel_e;

  typedef struct packed {
    logic                rdEn;
    rdSel_e              rdSel;
    logic                wrGen;
    logic                wrSts;
    logic                wrCntLo;
    logic                wrCntHi;
    logic                wrChCfg;
    logic                wrCmpLo;
    logic                wrCmpHi;
    logic                wrRtLo;
    logic                wrRtHi;
    logic [CH_IDX_W-1:0] chSel;
  } strobe_t;
endpackage

// File: rtl/evtTimerCtrl.sv
module evtTimerCtrl
  import evtTimerPkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  logic [CH_IDX_W-1:0] chRaw;
  logic                inChan;
  logic                chOk;
  logic [2:0]          slot;
  logic                wr;
  rdSel_e              sel;

  assign inChan = |busAddr[9:8];
  assign chRaw  = busAddr[9:5] - 5'd8;
  assign chOk   = chRaw < 5'(NUM_CH);
  assign slot   = busAddr[4:2];
  assign wr     = busValid & busWrite;

  always_comb begin
    sel = RD_ZERO;
    if (inChan) begin
      if (chOk) begin
        case (slot)
          3'd0: sel = RD_CHCFGLO;
          3'd1: sel = RD_CHCFGHI;
          3'd2: sel = RD_CMPLO;
          3'd3: sel = RD_CMPHI;
          3'd4: sel = RD_RTLO;
          3'd5: sel = RD_RTHI;
          default: sel = RD_ZERO;
        endcase
      end
    end else begin
      case (busAddr[7:2])
        6'h00: sel = RD_CAPLO;
        6'h01: sel = RD_CAPHI;
        6'h04: sel = RD_GEN;
        6'h08: sel = RD_STS;
        6'h3C: sel = RD_CNTLO;
        6'h3D: sel = RD_CNTHI;
        default: sel = RD_ZERO;
      endcase
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = sel;
    strobe.chSel   = chRaw;
    strobe.rdEn    = busValid & ~busWrite;
    strobe.wrGen   = wr && sel == RD_GEN;
    strobe.wrSts   = wr && sel == RD_STS;
    strobe.wrCntLo = wr && sel == RD_CNTLO;
    strobe.wrCntHi = wr && sel == RD_CNTHI;
    strobe.wrChCfg = wr && sel == RD_CHCFGLO;
    strobe.wrCmpLo = wr && sel == RD_CMPLO;
    strobe.wrCmpHi = wr && sel == RD_CMPHI;
    strobe.wrRtLo  = wr && sel == RD_RTLO;
    strobe.wrRtHi  = wr && sel == RD_RTHI;
  end
endmodule

// File: rtl/evtTimerData.sv
module evtTimerData
  import evtTimerPkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_CH-1:0]    stsSet,
  output logic [DATA_W-1:0]    busRdata,
  output logic [CNT_W-1:0]     counterOut,
  output logic                 counterRun,
  output logic                 legacyRoute,
  output logic [NUM_CH-1:0]    chArm,
  output logic [NUM_CH*32-1:0] chCfgOut,
  output logic [NUM_CH*64-1:0] chCmpOut,
  output logic [NUM_CH*64-1:0] chRouteOut
);
  localparam logic [31:0] CAP_LO = CAP_BASE | (32'(NUM_CH - 1) << 8);

  logic [CNT_W-1:0]  counter;
  logic [1:0]        genCfg;
  logic [NUM_CH-1:0] sts;
  logic [31:0]       chCfgW [NUM_CH];
  logic [63:0]       chCmp  [NUM_CH];
  logic [63:0]       chRt   [NUM_CH];
  logic [31:0]       rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counter <= '0;
      genCfg  <= '0;
      sts     <= '0;
    end else begin
      if (strobe.wrCntLo)      counter[31:0]  <= wdata;
      else if (strobe.wrCntHi) counter[63:32] <= wdata;
      else if (genCfg[0])      counter        <= counter + 1'b1;
      if (strobe.wrGen) genCfg <= wdata[1:0] & GEN_MASK;
      sts <= (sts & ~(strobe.wrSts ? wdata[NUM_CH-1:0] : '0))
           | (genCfg[0] ? stsSet : '0);
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = strobe.chSel == 5'(i);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        chCfgW[i] <= '0;
        chCmp[i]  <= '1;
        chRt[i]   <= '0;
      end else if (hit) begin
        if (strobe.wrChCfg) chCfgW[i]     <= wdata & CH_CFG_MASK;
        if (strobe.wrCmpLo) chCmp[i][31:0]  <= wdata;
        if (strobe.wrCmpHi) chCmp[i][63:32] <= wdata;
        if (strobe.wrRtLo)  chRt[i][31:0]   <= wdata;
        if (strobe.wrRtHi)  chRt[i][63:32]  <= wdata;
      end
    end
    assign chArm[i]              = genCfg[0] & chCfgW[i][2];
    assign chCfgOut[i*32 +: 32]  = chCfgW[i] | CH_CAP_BITS;
    assign chCmpOut[i*64 +: 64]  = chCmp[i];
    assign chRouteOut[i*64 +: 64] = chRt[i];
  end

  always_comb begin
    logic [31:0] cCfg, cCmpLo, cCmpHi, cRtLo, cRtHi;
    cCfg = '0; cCmpLo = '0; cCmpHi = '0; cRtLo = '0; cRtHi = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (strobe.chSel == 5'(i)) begin
        cCfg   = chCfgW[i] | CH_CAP_BITS;
        cCmpLo = chCmp[i][31:0];
        cCmpHi = chCmp[i][63:32];
        cRtLo  = chRt[i][31:0];
        cRtHi  = chRt[i][63:32];
      end
    end
    case (strobe.rdSel)
      RD_CAPLO:   rdMux = CAP_LO;
      RD_CAPHI:   rdMux = PERIOD_FS;
      RD_GEN:     rdMux = {30'd0, genCfg};
      RD_STS:     rdMux = 32'(sts);
      RD_CNTLO:   rdMux = counter[31:0];
      RD_CNTHI:   rdMux = counter[63:32];
      RD_CHCFGLO: rdMux = cCfg;
      RD_CHCFGHI: rdMux = CH_CFG_HI;
      RD_CMPLO:   rdMux = cCmpLo;
      RD_CMPHI:   rdMux = cCmpHi;
      RD_RTLO:    rdMux = cRtLo;
      RD_RTHI:    rdMux = cRtHi;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdMux;
  end

  assign counterOut  = counter;
  assign counterRun  = genCfg[0];
  assign legacyRoute = genCfg[1];
endmodule

// File: rtl/evtTimerRegs.sv
module evtTimerRegs
  import evtTimerPkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [9:0]           busAddr,
  input  logic [31:0]          busWdata,
  input  logic [NUM_CH-1:0]    stsSet,
  output logic [31:0]          busRdata,
  output logic [63:0]          counterOut,
  output logic                 counterRun,
  output logic                 legacyRoute,
  output logic [NUM_CH-1:0]    chArm,
  output logic [NUM_CH*32-1:0] chCfgOut,
  output logic [NUM_CH*64-1:0] chCmpOut,
  output logic [NUM_CH*64-1:0] chRouteOut
);
  strobe_t strobe;

  evtTimerCtrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr), .strobe(strobe)
  );

  evtTimerData #(.NUM_CH(NUM_CH), .PERIOD_FS(PERIOD_FS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdata(busWdata), .stsSet(stsSet),
    .busRdata(busRdata), .counterOut(counterOut), .counterRun(counterRun),
    .legacyRoute(legacyRoute), .chArm(chArm), .chCfgOut(chCfgOut),
    .chCmpOut(chCmpOut), .chRouteOut(chRouteOut)
  );
endmodule

// File: rtl/evtTimerRegs_chk.sv
module evtTimerRegs_chk #(
  parameter int          NUM_CH    = 3,
  parameter logic [31:0] PERIOD_FS = 32'd10_000_000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [9:0]        busAddr,
  input logic [31:0]       busRdata,
  input logic [63:0]       counterOut,
  input logic              counterRun,
  input logic [NUM_CH-1:0] chArm
);
  logic cntWr, rdReq, chanOob;
  assign cntWr   = busValid && busWrite && (busAddr[9:3] == 7'h1E);
  assign rdReq   = busValid && !busWrite;
  assign chanOob = (busAddr[9:5] >= 5'd8) && (busAddr[9:5] - 5'd8 >= 5'(NUM_CH));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!counterRun && !cntWr) |=> $stable(counterOut));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (counterRun && !cntWr) |=> counterOut == $past(counterOut) + 64'd1);

  p_disarm_r8: assert property (@(posedge clk) disable iff (!rstN)
    !counterRun |-> chArm == '0);

  p_cap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && busAddr == 10'h004) |=> busRdata == PERIOD_FS);

  p_oob_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && chanOob) |=> busRdata == 32'd0);

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> $stable(busRdata));
endmodule

bind evtTimerRegs evtTimerRegs_chk #(.NUM_CH(NUM_CH), .PERIOD_FS(PERIOD_FS)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .counterOut(counterOut),
  .counterRun(counterRun), .chArm(chArm)
);

// File: tb/evtTimerRegs_test.sv
module evtTimerRegs_test;
  localparam int          NCH    = 4;
  localparam logic [31:0] PER    = 32'h0098_9680;
  localparam logic [31:0] CAPLO  = 32'h8086_A001 | (32'(NCH - 1) << 8);

  logic clk = 0, rstN = 0, busValid = 0, busWrite = 0;
  logic [9:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [NCH-1:0] stsSet = '0, chArm;
  logic [63:0] counterOut;
  logic counterRun, legacyRoute;
  logic [NCH*32-1:0] chCfgOut;
  logic [NCH*64-1:0] chCmpOut, chRouteOut;

  int nTests = 0, nFail = 0;
  logic [31:0] rv, a, b;

  always #10 clk = ~clk;

  evtTimerRegs #(.NUM_CH(NCH), .PERIOD_FS(PER)) uut (.*);

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] ad, input logic [31:0] d);
    busValid = 1; busWrite = 1; busAddr = ad; busWdata = d;
    @(posedge clk); @(negedge clk);
    busValid = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [9:0] ad, output logic [31:0] d);
    busValid = 1; busWrite = 0; busAddr = ad;
    @(posedge clk); @(negedge clk);
    d = busRdata; busValid = 0;
  endtask

  function automatic logic [9:0] chA(input int ch, input int off);
    return 10'(32'h100 + ch * 32'h20 + off);
  endfunction

  initial begin
    #4_000_000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset values
    check("R1 run", counterRun, 0);
    check("R1 arm", chArm, 0);
    rd(10'h010, rv); check("R1 gen", rv, 0);
    rd(10'h0F0, rv); check("R1 cntlo", rv, 0);
    rd(10'h020, rv); check("R1 sts", rv, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(chA(c, 0), rv);     check("R1 chcfg", rv, 32'h30);
      rd(chA(c, 4), rv);     check("R1 chcfghi", rv, 32'h4);
      rd(chA(c, 8), rv);     check("R1 cmplo", rv, 32'hFFFF_FFFF);
      rd(chA(c, 12), rv);    check("R1 cmphi", rv, 32'hFFFF_FFFF);
      rd(chA(c, 16), rv);    check("R1 rt", rv, 0);
    end
    // R2 capability, read-only
    wr(10'h000, 32'h1234_5678); wr(10'h004, 32'h1);
    rd(10'h000, rv); check("R2 caplo", rv, CAPLO);
    rd(10'h004, rv); check("R2 caphi", rv, PER);
    // R3 general configuration
    wr(10'h010, 32'hFFFF_FFFE); rd(10'h010, rv); check("R3 mask", rv, 32'h2);
    check("R3 legacy", legacyRoute, 1);
    check("R3 run off", counterRun, 0);
    wr(10'h014, 32'hFFFF_FFFF); rd(10'h014, rv); check("R3 hi zero", rv, 0);
    wr(10'h010, 32'h0); check("R3 legacy clr", legacyRoute, 0);
    // R5 halves while halted, R4 hold
    wr(10'h0F0, 32'h100); wr(10'h0F4, 32'h5);
    rd(10'h0F0, rv); check("R5 lo", rv, 32'h100);
    rd(10'h0F4, rv); check("R5 hi", rv, 32'h5);
    repeat (5) @(negedge clk);
    rd(10'h0F0, rv); check("R4 frozen", rv, 32'h100);
    // R4 run
    wr(10'h010, 32'h1);
    rd(10'h0F0, a); check("R4 first", a, 32'h100);
    rd(10'h0F0, b); check("R4 step1", b, 32'h101);
    repeat (7) @(negedge clk);
    rd(10'h0F0, b); check("R4 step9", b, 32'h109);
    // R5 write while running
    wr(10'h0F0, 32'hFFFF_FFF0);
    rd(10'h0F0, rv); check("R5 running lo", rv, 32'hFFFF_FFF0);
    rd(10'h0F4, rv); check("R5 hi kept", rv, 32'h5);
    // stop, R4 freeze
    wr(10'h010, 32'h0);
    rd(10'h0F0, a); repeat (10) @(negedge clk); rd(10'h0F0, b);
    check("R4 freeze", b, a);
    // R6/R7 channels sweep
    for (int c = 0; c < NCH; c++) begin
      wr(chA(c, 0), 32'hFFFF_FFFF);
      rd(chA(c, 0), rv); check("R6 cfg ones", rv, 32'h7F7E);
      check("R6 cfg out", chCfgOut[c*32 +: 32], 32'h7F7E);
      wr(chA(c, 4), 32'h0); rd(chA(c, 4), rv); check("R6 hi ro", rv, 32'h4);
      wr(chA(c, 8),  32'h1111_0000 + 32'(c));
      wr(chA(c, 12), 32'h2222_0000 + 32'(c));
      wr(chA(c, 16), 32'h3333_0000 + 32'(c));
      wr(chA(c, 20), 32'h4444_0000 + 32'(c));
      rd(chA(c, 8), rv);  check("R7 cmplo", rv, 32'h1111_0000 + 32'(c));
      rd(chA(c, 12), rv); check("R7 cmphi", rv, 32'h2222_0000 + 32'(c));
      rd(chA(c, 20), rv); check("R7 rthi", rv, 32'h4444_0000 + 32'(c));
      check("R7 cmp out", chCmpOut[c*64 +: 64], {32'h2222_0000 + 32'(c), 32'h1111_0000 + 32'(c)});
      check("R7 rt out", chRouteOut[c*64 +: 64], {32'h4444_0000 + 32'(c), 32'h3333_0000 + 32'(c)});
    end
    // R8 arming
    check("R8 halted", chArm, 0);
    wr(10'h010, 32'h1); check("R8 all", chArm, 4'b1111);
    wr(chA(1, 0), 32'h0); check("R8 ch1 off", chArm, 4'b1101);
    rd(chA(1, 0), rv); check("R6 cfg zero", rv, 32'h30);
    // R9 status
    stsSet = 4'b0110; @(posedge clk); @(negedge clk); stsSet = '0;
    rd(10'h020, rv); check("R9 set", rv, 32'h6);
    wr(10'h020, 32'h4); rd(10'h020, rv); check("R9 w1c", rv, 32'h2);
    wr(10'h020, 32'h0); rd(10'h020, rv); check("R9 w0", rv, 32'h2);
    wr(10'h010, 32'h0); check("R8 disarm", chArm, 0);
    stsSet = 4'b0001; @(posedge clk); @(negedge clk); stsSet = '0;
    rd(10'h020, rv); check("R9 set gated", rv, 32'h2);
    wr(10'h020, 32'h2); rd(10'h020, rv); check("R9 clear", rv, 32'h0);
    // R10 out-of-range channels and unused slots
    for (int c = NCH; c < 24; c++) begin
      wr(chA(c, 0), 32'hFFFF_FFFF); wr(chA(c, 8), 32'h0);
      rd(chA(c, 0), rv); check("R10 oob cfg", rv, 0);
      rd(chA(c, 8), rv); check("R10 oob cmp", rv, 0);
    end
    check("R10 cfg kept", chCfgOut, {32'h7F7E, 32'h7F7E, 32'h30, 32'h7F7E});
    rd(chA(0, 8), rv); check("R10 cmp kept", rv, 32'h1111_0000);
    for (int c = 0; c < NCH; c++) begin
      wr(chA(c, 24), 32'hFFFF_FFFF);
      rd(chA(c, 24), rv); check("R10 slot6", rv, 0);
      rd(chA(c, 28), rv); check("R10 slot7", rv, 0);
    end
    for (int w = 0; w < 64; w++) begin
      if (w == 0 || w == 1 || w == 4 || w == 8 || w == 60 || w == 61) continue;
      wr(10'(w * 4), 32'hFFFF_FFFF);
      rd(10'(w * 4), rv); check("R10 unmapped", rv, 0);
    end
    rd(10'h010, rv); check("R10 gen kept", rv, 0);
    rd(10'h020, rv); check("R10 sts kept", rv, 0);
    // R11 read data holds between reads
    rd(10'h004, rv);
    repeat (3) @(negedge clk);
    check("R11 hold", busRdata, PER);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule